// File: doc/BRIEF.md
# Synchronous USB Bridge Word Writer

This block moves 32-bit sample words from an internal first-word-fall-through FIFO into an external USB bridge chip that uses a synchronous FIFO-style parallel interface. It runs on the clock that the bridge supplies. It watches the bridge's active-low ready-to-accept flag. Once that flag has been low for a fixed start-up delay, the block pulls its active-low write strobe down and places one word on the bus in every clock cycle. All byte-enable lines stay high, so the bridge only ever receives whole words.

The upstream FIFO shows its head word on `up_data` and raises `up_empty` when it holds nothing. The writer pops it only in cycles where a word actually crosses to the bridge. As a result, the stream reaches the bridge in order, with no word lost and none sent twice. If the bridge withdraws its ready flag, the strobe drops at once, and the start-up delay has to run again from the beginning. If the FIFO runs dry, the strobe pauses. It resumes as soon as a word arrives, without another delay, as long as the bridge stayed ready.

Top module: `usbw_writer`

## Requirements
- R1: Every bit of `bus_be` is 1 in every cycle, including during reset.
- R2: `wr_strobe_n` may be low only in a cycle in which `txrdy_n` is low and was also sampled low at each of the preceding WAIT_CYC rising edges (default 2). With the FIFO non-empty, the strobe goes low in the cycle that follows the second such edge.
- R3: In any cycle in which `txrdy_n` is high, `wr_strobe_n` is high in that same cycle.
- R4: In any cycle in which `up_empty` is high, `wr_strobe_n` is high. When a word arrives while `txrdy_n` has stayed low, the strobe goes low in that same cycle, with no new wait.
- R5: `up_pop` is 1 exactly when `wr_strobe_n` is 0, `txrdy_n` is 0 and `up_empty` is 0. The words the bridge captures are the upstream words in order, with none lost or repeated.
- R6: While `wr_strobe_n` is low, `bus_data` equals `up_data`. While it is high, `bus_data` holds the last word transferred.
- R7: During and right after reset, `wr_strobe_n` is 1, `up_pop` is 0, `bus_data` is 0, and the wait count is zero.
- R8: If `txrdy_n` is sampled high at any edge, the wait restarts. After it falls again, the full WAIT_CYC-edge delay applies before the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the USB bridge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_data | input | DATA_W (32) | Head word of the upstream FIFO |
| up_empty | input | 1 | Upstream FIFO has no word |
| up_pop | output | 1 | Pop the upstream FIFO at the next edge |
| txrdy_n | input | 1 | Bridge ready to accept data, active low |
| wr_strobe_n | output | 1 | Write strobe to the bridge, active low |
| bus_data | output | DATA_W (32) | Data bus to the bridge |
| bus_be | output | DATA_W/8 (4) | Byte enables, all held high |

## Verification
The strobe, `up_pop` and the live bus word respond to `txrdy_n` and `up_empty` within the same cycle. The start-up delay is due in the cycle after the second rising edge at which `txrdy_n` was sampled low. The bench drives inputs on the falling edge and samples 1 ns later, before the next rising edge. It keeps its own count of low-sampled edges, updated on each falling edge, to predict the strobe for every cycle. A word counts as transferred when the bench sees strobe and ready both low at that sampling point. The bench's FIFO model advances only on the following falling edge, after the rising edge that consumed the word.

// File: rtl/usbw_pkg.sv
package usbw_pkg;

  // next value of the ready-wait counter: clears when the bridge is not
  // ready at the sampling edge, otherwise climbs and saturates at limit
  function automatic int wait_next(input int cnt, input bit ready_low, input int limit);
    if (!ready_low) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

  // a word crosses to the bridge when the wait is over, the bridge is
  // ready now and the upstream FIFO has a word to give
  function automatic bit write_fire(input bit wait_done, input bit ready_low, input bit empty);
    return wait_done && ready_low && !empty;
  endfunction

endpackage

// File: rtl/usbw_ready_timer.sv
module usbw_ready_timer #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txrdy_n,
  output logic wait_done
);
  import usbw_pkg::*;

  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(wait_next(int'(cnt_q), !txrdy_n, WAIT_CYC));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wait_done = (int'(cnt_q) == WAIT_CYC);

  AST_NOT_READY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    txrdy_n |=> !wait_done); // R8

  AST_RESET_CLEARS_WAIT: assert property (@(posedge clk)
    !rst_n |=> !wait_done); // R7

endmodule

// File: rtl/usbw_strobe_ctrl.sv
module usbw_strobe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_done,
  input  logic txrdy_n,
  input  logic up_empty,
  output logic fire,
  output logic wr_strobe_n,
  output logic up_pop
);
  import usbw_pkg::*;

  always_comb begin
    fire        = rst_n && write_fire(wait_done, !txrdy_n, up_empty);
    wr_strobe_n = !fire;
    up_pop      = fire;
  end

  AST_IDLE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    txrdy_n |-> wr_strobe_n); // R3

  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    up_empty |-> wr_strobe_n); // R4

  AST_POP_ONLY_ON_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    up_pop |-> (!up_empty && !txrdy_n)); // R5

endmodule

// File: rtl/usbw_data_path.sv
module usbw_data_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] up_data,
  output logic [DATA_W-1:0] bus_data,
  output logic [DATA_W/8-1:0] bus_be
);
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    hold_q <= '0;
    else if (fire) hold_q <= up_data;
  end

  assign bus_data = fire ? up_data : hold_q;

  for (genvar g = 0; g < BE_W; g++) begin : g_be
    assign bus_be[g] = 1'b1;
  end

  AST_BUS_HOLDS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && $past(!fire)) |-> $stable(bus_data)); // R6

  AST_BUS_ZERO_AFTER_RESET: assert property (@(posedge clk)
    (!rst_n && !fire) |=> (fire || bus_data == '0)); // R7

endmodule

// File: rtl/usbw_writer.sv
module usbw_writer #(
  parameter int DATA_W   = 32,
  parameter int WAIT_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   up_data,
  input  logic                up_empty,
  output logic                up_pop,
  input  logic                txrdy_n,
  output logic                wr_strobe_n,
  output logic [DATA_W-1:0]   bus_data,
  output logic [DATA_W/8-1:0] bus_be
);
  localparam int RUN_W = $clog2(WAIT_CYC + 1);

  logic wait_done;
  logic fire;

  usbw_ready_timer #(.WAIT_CYC(WAIT_CYC)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .txrdy_n   (txrdy_n),
    .wait_done (wait_done)
  );

  usbw_strobe_ctrl strobe_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_done   (wait_done),
    .txrdy_n     (txrdy_n),
    .up_empty    (up_empty),
    .fire        (fire),
    .wr_strobe_n (wr_strobe_n),
    .up_pop      (up_pop)
  );

  usbw_data_path #(.DATA_W(DATA_W)) data_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .up_data  (up_data),
    .bus_data (bus_data),
    .bus_be   (bus_be)
  );

  // checker counter: consecutive edges at which the ready flag was low
  logic [RUN_W-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || txrdy_n)              low_run_q <= '0;
    else if (int'(low_run_q) < WAIT_CYC) low_run_q <= low_run_q + 1'b1;
  end

  AST_START_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |-> (int'(low_run_q) == WAIT_CYC)); // R2

  AST_BYTES_ALL_ON: assert property (@(posedge clk)
    &bus_be); // R1

  AST_BUS_FOLLOWS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |-> (bus_data == up_data)); // R6

endmodule

// File: tb/usbw_writer_tb_top.sv
module usbw_writer_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] up_data;
  logic          up_empty;
  logic          up_pop;
  logic          txrdy_n;
  logic          wr_strobe_n;
  logic [DW-1:0] bus_data;
  logic [3:0]    bus_be;

  int errors = 0;
  int checks = 0;
  int rd = 0, wr = 0;       // bench FIFO pointers
  bit pend = 0;             // a word was taken; advance after the edge
  int bcnt = 0;             // bench count of low-sampled edges
  logic cur_txr = 1'b1;
  logic [DW-1:0] rx [64];
  int rxn = 0;
  logic [DW-1:0] last_sent = '0;

  always #2 clk = ~clk;     // 250 MHz

  function automatic logic [DW-1:0] pat(input int i);
    return 32'hC3A50000 ^ (32'(i) * 32'h01010101) ^ 32'(i << 4);
  endfunction

  assign up_data  = pat(rd);
  assign up_empty = (rd == wr);

  usbw_writer dut_i (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_empty(up_empty),
    .up_pop(up_pop), .txrdy_n(txrdy_n), .wr_strobe_n(wr_strobe_n),
    .bus_data(bus_data), .bus_be(bus_be)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: apply inputs at the falling edge, sample 1 ns later
  task automatic cyc(input logic txr, input int push);
    logic exp_strobe_n;
    @(negedge clk);
    if (pend) rd++;
    pend = 0;
    if (!cur_txr) bcnt = (bcnt < 2) ? bcnt + 1 : 2; else bcnt = 0;
    cur_txr = txr;
    txrdy_n = txr;
    wr += push;
    #1;
    exp_strobe_n = !(bcnt == 2 && !txr && rd != wr);
    chk(wr_strobe_n == exp_strobe_n, "R2", "strobe vs wait model", 32'(wr_strobe_n), 32'(exp_strobe_n));
    chk(up_pop == !exp_strobe_n, "R5", "pop", 32'(up_pop), 32'(!exp_strobe_n));
    chk(bus_be == 4'hF, "R1", "byte enables", 32'(bus_be), 32'hF);
    if (!wr_strobe_n && !txrdy_n) begin
      chk(bus_data == pat(rd), "R6", "live bus word", bus_data, pat(rd));
      rx[rxn] = bus_data; rxn++; pend = 1; last_sent = pat(rd);
    end else begin
      chk(bus_data == last_sent, "R6", "held bus word", bus_data, last_sent);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; txrdy_n = 1'b0; cur_txr = 1'b1; bcnt = 0;
    wr = 3;
    repeat (3) @(negedge clk);
    #1;
    chk(wr_strobe_n == 1'b1, "R7", "strobe in reset", 32'(wr_strobe_n), 32'd1);
    chk(up_pop == 1'b0, "R7", "pop in reset", 32'(up_pop), 32'd0);
    chk(bus_data == '0, "R7", "bus in reset", bus_data, '0);
    chk(bus_be == 4'hF, "R1", "byte enables in reset", 32'(bus_be), 32'hF);
    @(negedge clk);
    txrdy_n = 1'b1; rst_n = 1'b1; wr = 0;
    #1;
    chk(wr_strobe_n == 1'b1 && bus_data == '0, "R7", "state at release", {31'd0, wr_strobe_n}, 32'd1);
  endtask

  // the two-edge start-up delay and a streamed burst until empty
  task automatic t_start_burst;
    cyc(1'b0, 4);
    chk(wr_strobe_n == 1'b1, "R2", "no strobe before first edge", 32'(wr_strobe_n), 32'd1);
    cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b1, "R2", "no strobe after one edge", 32'(wr_strobe_n), 32'd1);
    cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b0, "R2", "strobe after two edges", 32'(wr_strobe_n), 32'd0);
    repeat (4) cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b1, "R4", "strobe stops when empty", 32'(wr_strobe_n), 32'd1);
    chk(rxn == 4, "R5", "burst word count", 32'(rxn), 32'd4);
  endtask

  // new word while ready stayed low: no fresh wait
  task automatic t_empty_resume;
    cyc(1'b0, 1);
    chk(wr_strobe_n == 1'b0, "R4", "resume in same cycle", 32'(wr_strobe_n), 32'd0);
    cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b1, "R4", "empty again", 32'(wr_strobe_n), 32'd1);
    repeat (2) cyc(1'b0, 0);
    chk(bus_data == pat(4), "R6", "held last word", bus_data, pat(4));
  endtask

  // ready withdrawn mid-burst, then the wait restarts
  task automatic t_pause_restart;
    cyc(1'b0, 6);
    cyc(1'b0, 0);
    cyc(1'b1, 0);
    chk(wr_strobe_n == 1'b1, "R3", "strobe drops with ready high", 32'(wr_strobe_n), 32'd1);
    chk(up_pop == 1'b0, "R3", "no pop while not ready", 32'(up_pop), 32'd0);
    cyc(1'b1, 0);
    cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b1, "R8", "restart: none before edge", 32'(wr_strobe_n), 32'd1);
    cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b1, "R8", "restart: none after one edge", 32'(wr_strobe_n), 32'd1);
    cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b0, "R8", "restart: strobe after two edges", 32'(wr_strobe_n), 32'd0);
    // one-cycle glitch high also restarts
    cyc(1'b1, 0);
    cyc(1'b0, 0);
    cyc(1'b0, 0);
    chk(wr_strobe_n == 1'b1, "R8", "glitch restart", 32'(wr_strobe_n), 32'd1);
    repeat (8) cyc(1'b0, 0);
    cyc(1'b1, 0);
  endtask

  task automatic t_order;
    chk(rxn == wr, "R5", "total words received", 32'(rxn), 32'(wr));
    for (int k = 0; k < rxn; k++)
      chk(rx[k] == pat(k), "R5", "word order", rx[k], pat(k));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_start_burst();
        t_empty_resume();
        t_pause_restart();
        t_order();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog expired: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule